// File: doc/BRIEF.md
# Memory Request Priority Arbiter

This block decides which pending request the memory sequencer serves next. Eight request sources each pulse a request input, and the pulse is captured in a per-source pending latch. The sources are SDRAM mode programming, refresh, victim write-back, DMA read, DMA translation fill, DMA write, PCI read completion and CPU miss. Whenever the sequencer reports that it is ready and no grant is outstanding, the arbiter ranks the pending latches and issues a registered one-hot grant that lasts one cycle.

Three status inputs move sources between two ranks. Overdue refresh jumps to just below mode programming. A victim write-back with both victim buffers occupied ranks above DMA read. A DMA write with both write buffers occupied ranks above PCI completion and CPU misses. Without these conditions, victim write-back, DMA write and refresh sit below CPU misses, in that order. After a grant the arbiter waits for the sequencer's acknowledge. The acknowledge clears the granted latch and reopens arbitration, so requests that arrive in the meantime wait for the next round.

Top module: `mem_req_arbiter`

## Requirements
- R1: After reset no request is pending and `grant_o` stays zero while no request input has been pulsed, even with `seq_ready_i` high.
- R2: A single-cycle pulse on `req_i[k]` is held pending until that source is granted and acknowledged. `grant_o` never names a source that was not pending. Bit positions of `req_i` and `grant_o`: 0 mode set, 1 refresh, 2 victim write-back, 3 DMA read, 4 DMA translation fill, 5 DMA write, 6 PCI read completion, 7 CPU miss.
- R3: A grant is raised only in the cycle after an arbitration cycle in which `seq_ready_i` was high. `grant_o` is one-hot or zero, and each grant lasts exactly one cycle.
- R4: A pending mode-set request always wins, including over overdue refresh. Among unpromoted sources the order is DMA read, then translation fill, then PCI completion, then CPU miss.
- R5: With `refresh_overdue_i` high, a pending refresh wins over every source except mode set.
- R6: With `victim_full_i` high, a pending victim write-back ranks directly below overdue refresh and above DMA read.
- R7: With `dmaw_full_i` high, a pending DMA write ranks directly below translation fill and above PCI completion and CPU miss.
- R8: With no status input high, CPU miss beats victim write-back, which beats DMA write, which beats refresh.
- R9: Between a grant and its acknowledge no further grant is issued. `ack_i` clears only the granted source's latch.
- R10: `ack_i` raised while no grant is outstanding has no effect on any pending request.
- R11: A new request from a source that arrives in the same cycle as the acknowledge of that source's grant stays pending and is granted again later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | 8 | Request pulses, one bit per source |
| refresh_overdue_i | input | 1 | Refresh is overdue, promote refresh |
| victim_full_i | input | 1 | Both victim buffers occupied, promote victim write-back |
| dmaw_full_i | input | 1 | Both DMA write buffers occupied, promote DMA write |
| seq_ready_i | input | 1 | Sequencer idle and able to accept a grant |
| ack_i | input | 1 | Sequencer acknowledge of the outstanding grant |
| grant_o | output | 8 | One-hot grant, one cycle wide |

## Verification
The assertions assume that the status inputs are stable in the arbitration cycle in which they are sampled. They also assume that the sequencer raises `ack_i` only in response to a grant it has seen. The bench changes status inputs only while `seq_ready_i` is low or before any request is latched. It also drives `ack_i` in the grant cycle itself, except in the two scenarios that deliberately delay the acknowledge or send a stray one. Priority is checked by latching a whole set of requests with the sequencer held busy, then draining them one grant at a time and comparing the grant order with the expected rank list.

// File: rtl/mra_pkg.sv
package mra_pkg;

    localparam int NSRC  = 8;
    localparam int NSLOT = 11;

    localparam int SRC_MODE = 0;
    localparam int SRC_REF  = 1;
    localparam int SRC_VICT = 2;
    localparam int SRC_DRD  = 3;
    localparam int SRC_XLT  = 4;
    localparam int SRC_DWR  = 5;
    localparam int SRC_PCI  = 6;
    localparam int SRC_CPU  = 7;

    typedef enum logic [1:0] {
        PROMO_NONE = 2'd0,
        PROMO_REF  = 2'd1,
        PROMO_VICT = 2'd2,
        PROMO_DWR  = 2'd3
    } promo_e;

    typedef enum logic {
        CTL_IDLE = 1'b0,
        CTL_WAIT = 1'b1
    } ctl_state_e;

    // Source occupying each rank slot; slot 0 is the highest rank.
    function automatic int slot_src(input int slot);
        case (slot)
            0:       return SRC_MODE;
            1:       return SRC_REF;
            2:       return SRC_VICT;
            3:       return SRC_DRD;
            4:       return SRC_XLT;
            5:       return SRC_DWR;
            6:       return SRC_PCI;
            7:       return SRC_CPU;
            8:       return SRC_VICT;
            9:       return SRC_DWR;
            default: return SRC_REF;
        endcase
    endfunction

    // Status condition that gates each slot, if any.
    function automatic promo_e slot_promo(input int slot);
        case (slot)
            1:       return PROMO_REF;
            2:       return PROMO_VICT;
            5:       return PROMO_DWR;
            default: return PROMO_NONE;
        endcase
    endfunction

endpackage

// File: rtl/mra_req_latch.sv
module mra_req_latch #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_i,
    input  logic [W-1:0] clr_i,
    output logic [W-1:0] pend_o
);

    logic [W-1:0] pend_d;
    logic [W-1:0] pend_q;

    // A fresh request wins over a clear in the same cycle.
    for (genvar i = 0; i < W; i++) begin : g_bit
        always_comb begin
            pend_d[i] = set_i[i] | (pend_q[i] & ~clr_i[i]);
        end

        assert_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_i[i] && !set_i[i]) |=> !pend_q[i]);

        assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
            (pend_q[i] && !clr_i[i]) |=> pend_q[i]);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= pend_d;
    end

    assign pend_o = pend_q;

endmodule

// File: rtl/mra_prio_pick.sv
module mra_prio_pick
    import mra_pkg::*;
(
    input  logic [NSRC-1:0] pend_i,
    input  logic            refresh_overdue_i,
    input  logic            victim_full_i,
    input  logic            dmaw_full_i,
    output logic            any_o,
    output logic [NSRC-1:0] pick_o
);

    logic [NSLOT-1:0] slot_req;

    for (genvar s = 0; s < NSLOT; s++) begin : g_slot
        localparam int     SRC   = slot_src(s);
        localparam promo_e PROMO = slot_promo(s);
        logic cond;
        if (PROMO == PROMO_REF) begin : g_ref
            assign cond = refresh_overdue_i;
        end else if (PROMO == PROMO_VICT) begin : g_vict
            assign cond = victim_full_i;
        end else if (PROMO == PROMO_DWR) begin : g_dwr
            assign cond = dmaw_full_i;
        end else begin : g_none
            assign cond = 1'b1;
        end
        assign slot_req[s] = pend_i[SRC] & cond;
    end

    always_comb begin
        logic found;
        pick_o = '0;
        found  = 1'b0;
        for (int s = 0; s < NSLOT; s++) begin
            if (!found && slot_req[s]) begin
                pick_o[slot_src(s)] = 1'b1;
                found = 1'b1;
            end
        end
        any_o = |slot_req;
    end

endmodule

// File: rtl/mra_grant_ctrl.sv
module mra_grant_ctrl
    import mra_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            seq_ready_i,
    input  logic            ack_i,
    input  logic            any_i,
    input  logic [NSRC-1:0] pick_i,
    output logic [NSRC-1:0] grant_o,
    output logic [NSRC-1:0] clr_o
);

    typedef struct packed {
        ctl_state_e      st;
        logic [NSRC-1:0] gnt;
        logic [NSRC-1:0] held;
    } ctl_t;

    ctl_t ctl_d;
    ctl_t ctl_q;

    always_comb begin
        ctl_d     = ctl_q;
        ctl_d.gnt = '0;
        clr_o     = '0;
        case (ctl_q.st)
            CTL_IDLE: begin
                if (seq_ready_i && any_i) begin
                    ctl_d.gnt  = pick_i;
                    ctl_d.held = pick_i;
                    ctl_d.st   = CTL_WAIT;
                end
            end
            default: begin
                if (ack_i) begin
                    clr_o      = ctl_q.held;
                    ctl_d.held = '0;
                    ctl_d.st   = CTL_IDLE;
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q.st   <= CTL_IDLE;
            ctl_q.gnt  <= '0;
            ctl_q.held <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign grant_o = ctl_q.gnt;

    assert_grant_ready_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (|ctl_q.gnt) |-> $past(seq_ready_i));

    assert_grant_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (|ctl_q.gnt) |=> (ctl_q.gnt == '0));

    assert_wait_no_grant_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.st == CTL_WAIT && !ack_i) |=> (ctl_q.gnt == '0));

    assert_idle_no_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.st == CTL_IDLE) |-> (clr_o == '0));

endmodule

// File: rtl/mem_req_arbiter.sv
module mem_req_arbiter
    import mra_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] req_i,
    input  logic            refresh_overdue_i,
    input  logic            victim_full_i,
    input  logic            dmaw_full_i,
    input  logic            seq_ready_i,
    input  logic            ack_i,
    output logic [NSRC-1:0] grant_o
);

    logic [NSRC-1:0] pend;
    logic [NSRC-1:0] pick;
    logic [NSRC-1:0] clr;
    logic            any_pend;

    mra_req_latch #(.W(NSRC)) u_latch (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (req_i),
        .clr_i  (clr),
        .pend_o (pend)
    );

    mra_prio_pick u_pick (
        .pend_i            (pend),
        .refresh_overdue_i (refresh_overdue_i),
        .victim_full_i     (victim_full_i),
        .dmaw_full_i       (dmaw_full_i),
        .any_o             (any_pend),
        .pick_o            (pick)
    );

    mra_grant_ctrl u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .seq_ready_i (seq_ready_i),
        .ack_i       (ack_i),
        .any_i       (any_pend),
        .pick_i      (pick),
        .grant_o     (grant_o),
        .clr_o       (clr)
    );

    assert_onehot_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant_o));

    assert_grant_pending_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (|grant_o) |-> ((grant_o & $past(pend)) != '0));

    assert_mode_first_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ((|grant_o) && $past(pend[SRC_MODE])) |-> grant_o[SRC_MODE]);

    assert_overdue_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ((|grant_o) && $past(refresh_overdue_i && pend[SRC_REF] && !pend[SRC_MODE]))
        |-> grant_o[SRC_REF]);

endmodule

// File: tb/mem_req_arbiter_bench.sv
module mem_req_arbiter_bench;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] req = '0;
    logic       ovd = 1'b0;
    logic       vfull = 1'b0;
    logic       dfull = 1'b0;
    logic       ready = 1'b0;
    logic       ack = 1'b0;
    logic [7:0] grant;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    mem_req_arbiter u_mem_req_arbiter (
        .clk               (clk),
        .rst_n             (rst_n),
        .req_i             (req),
        .refresh_overdue_i (ovd),
        .victim_full_i     (vfull),
        .dmaw_full_i       (dfull),
        .seq_ready_i       (ready),
        .ack_i             (ack),
        .grant_o           (grant)
    );

    task automatic check(input bit ok, input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
        end
    endtask

    task automatic pulse_req(input logic [7:0] bits);
        @(negedge clk);
        req = bits;
        @(negedge clk);
        req = '0;
    endtask

    // Waits on negedges until a grant shows, up to a limit.
    task automatic wait_grant(output logic [7:0] g);
        g = '0;
        for (int i = 0; i < 20; i++) begin
            if (grant != '0) begin
                g = grant;
                break;
            end
            @(negedge clk);
        end
    endtask

    // Acknowledges in the grant cycle and checks the grant lasted one cycle.
    task automatic ack_now(input string tag);
        ack = 1'b1;
        @(negedge clk);
        ack = 1'b0;
        check(grant == '0, tag, grant, 8'h00);
    endtask

    task automatic drain(input logic [7:0] exp[], input string tag);
        logic [7:0] g;
        foreach (exp[i]) begin
            wait_grant(g);
            check(g == exp[i], tag, g, exp[i]);
            ack_now({tag, " R3 pulse"});
        end
        repeat (3) begin
            @(negedge clk);
            check(grant == '0, {tag, " R2 drained"}, grant, 8'h00);
        end
    endtask

    task automatic t_reset;
        ready = 1'b1;
        repeat (4) begin
            @(negedge clk);
            check(grant == '0, "R1 idle after reset", grant, 8'h00);
        end
    endtask

    task automatic t_single;
        logic [7:0] exp[] = '{8'h80};
        ready = 1'b1;
        pulse_req(8'h80);
        drain(exp, "R2 single cpu");
    endtask

    task automatic t_ready_gate;
        logic [7:0] g;
        ready = 1'b0;
        pulse_req(8'h08);
        repeat (5) begin
            @(negedge clk);
            check(grant == '0, "R3 no grant while busy", grant, 8'h00);
        end
        ready = 1'b1;
        @(negedge clk);
        wait_grant(g);
        check(g == 8'h08, "R3 grant after ready", g, 8'h08);
        ack_now("R3 pulse");
    endtask

    task automatic t_order_plain;
        logic [7:0] exp[] = '{8'h01, 8'h08, 8'h10, 8'h40, 8'h80, 8'h04, 8'h20, 8'h02};
        ready = 1'b0;
        ovd = 1'b0; vfull = 1'b0; dfull = 1'b0;
        pulse_req(8'hFF);
        ready = 1'b1;
        drain(exp, "R4 R8 plain order");
    endtask

    task automatic t_order_promoted;
        logic [7:0] exp[] = '{8'h02, 8'h04, 8'h08, 8'h10, 8'h20, 8'h40, 8'h80};
        ready = 1'b0;
        ovd = 1'b1; vfull = 1'b1; dfull = 1'b1;
        pulse_req(8'hFE);
        ready = 1'b1;
        drain(exp, "R5 R6 R7 promoted order");
        ovd = 1'b0; vfull = 1'b0; dfull = 1'b0;
    endtask

    task automatic t_mode_over_overdue;
        logic [7:0] exp[] = '{8'h01, 8'h02};
        ready = 1'b0;
        ovd = 1'b1;
        pulse_req(8'h03);
        ready = 1'b1;
        drain(exp, "R4 mode over overdue refresh");
        ovd = 1'b0;
    endtask

    task automatic t_partial_promo;
        // Victim full only: victim above DMA read, DMA write stays below CPU.
        logic [7:0] exp[] = '{8'h04, 8'h08, 8'h80, 8'h20};
        ready = 1'b0;
        vfull = 1'b1;
        pulse_req(8'hAC);
        ready = 1'b1;
        drain(exp, "R6 R7 victim promoted only");
        vfull = 1'b0;
    endtask

    task automatic t_no_regrant;
        logic [7:0] g;
        ready = 1'b0;
        pulse_req(8'hC0);
        ready = 1'b1;
        @(negedge clk);
        wait_grant(g);
        check(g == 8'h40, "R9 first grant pci", g, 8'h40);
        repeat (4) begin
            @(negedge clk);
            check(grant == '0, "R9 no grant before ack", grant, 8'h00);
        end
        ack = 1'b1;
        @(negedge clk);
        ack = 1'b0;
        wait_grant(g);
        check(g == 8'h80, "R9 other latch kept", g, 8'h80);
        ack_now("R9 pulse");
    endtask

    task automatic t_ack_idle;
        logic [7:0] g;
        ready = 1'b0;
        pulse_req(8'h10);
        @(negedge clk);
        ack = 1'b1;
        @(negedge clk);
        ack = 1'b0;
        @(negedge clk);
        ready = 1'b1;
        @(negedge clk);
        wait_grant(g);
        check(g == 8'h10, "R10 stray ack ignored", g, 8'h10);
        ack_now("R10 pulse");
    endtask

    task automatic t_req_at_ack;
        logic [7:0] g;
        ready = 1'b1;
        pulse_req(8'h80);
        wait_grant(g);
        check(g == 8'h80, "R11 first cpu grant", g, 8'h80);
        ack = 1'b1;
        req = 8'h80;
        @(negedge clk);
        ack = 1'b0;
        req = '0;
        wait_grant(g);
        check(g == 8'h80, "R11 re-request kept", g, 8'h80);
        ack_now("R11 pulse");
        repeat (3) begin
            @(negedge clk);
            check(grant == '0, "R11 cleared after second ack", grant, 8'h00);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_single();
        t_ready_gate();
        t_order_plain();
        t_order_promoted();
        t_mode_over_overdue();
        t_partial_promo();
        t_no_regrant();
        t_ack_idle();
        t_req_at_ack();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule